// File: doc/BRIEF.md
# Hashed Page-Table Probe Engine

This block turns a 16-bit virtual page number into the base and bounds of the pagegroup that holds it. The translation entries sit in a 256-slot hash table kept in one single-port on-chip RAM. Each slot stores a valid flag, the full virtual page number as a tag, and the base/bounds payload. A lookup starts at a slot picked by folding the page number. The engine then walks the table one slot at a time until it finds the matching tag, meets an empty slot, or has tried every slot.

A match loads the bounds output and then the base (mapping) output, one cycle each, and pulses a hit strobe. An empty slot, or an exhausted table, ends the lookup with a miss strobe. A miss tells the surrounding logic that the page has to come from disk, and that handling lives outside this block. A fill port writes whole slots into the table. It only has effect while the engine is idle, so table writes never collide with a probe's RAM read.

Top module: `pgProbeEngine`

## Requirements
- R1: After reset, busy, doneHit and doneMiss are 0, and baseOut and boundsOut are 0.
- R2: The first slot probed is lookupVpn[15:8] XOR lookupVpn[7:0]. A lookup whose entry sits in that slot raises doneHit 6 cycles after the clock edge that accepts it.
- R3: When a probed slot is valid but holds another tag, the next slot probed is the previous index plus 1, wrapping from 255 to 0. Each such extra probe adds 3 cycles.
- R4: A slot matches only when its valid bit is 1 and its 16-bit tag equals the requested page number exactly.
- R5: On a hit at probe k, doneHit is a one-cycle pulse 3k+3 cycles after acceptance. boundsOut takes the entry's bounds one cycle before baseOut takes its base, and both hold the entry's payload when doneHit is high.
- R6: A probed slot with its valid bit 0 ends the search. doneMiss pulses for one cycle 3k+1 cycles after acceptance, where k is the probe that found the empty slot, and baseOut and boundsOut keep their previous values.
- R7: If 256 probes find no match and no empty slot, the lookup ends with doneMiss 769 cycles after acceptance.
- R8: A fill (fillValid high) writes {fillEntryValid, fillTag, fillBase, fillBounds} into slot fillIndex only in a cycle where busy is 0. A fill while busy is 1 is dropped.
- R9: lookupValid is ignored while busy is 1. No second lookup starts, and no extra done pulse follows.
- R10: busy is 1 from the cycle after acceptance until the cycle in which doneHit or doneMiss is raised, and it is 0 in that done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Start a lookup (taken when idle) |
| lookupVpn | input | 16 | Virtual page number to resolve |
| fillValid | input | 1 | Write one table slot |
| fillIndex | input | 8 | Slot to write |
| fillEntryValid | input | 1 | Valid bit written to the slot |
| fillTag | input | 16 | Tag written to the slot |
| fillBase | input | 16 | Base payload written to the slot |
| fillBounds | input | 8 | Bounds payload written to the slot |
| busy | output | 1 | A lookup is in progress |
| doneHit | output | 1 | One-cycle pulse: lookup found its entry |
| doneMiss | output | 1 | One-cycle pulse: page not in table |
| baseOut | output | 16 | Mapping register, loaded on a hit |
| boundsOut | output | 8 | Bounds register, loaded on a hit |

## Verification
The bench goes after the following corner cases:
- Slot collisions that force linear reprobing, including a chain that wraps from slot 255 to slot 0. A design that used a different step or failed to wrap would miss or return the wrong payload.
- A valid slot whose tag differs from the sought page. A design that compared only the valid bit would report a false hit.
- A completely full table with no matching tag. Without the probe limit the engine would spin until the watchdog fires.
- Fills and lookups issued while a lookup is in progress. A design that honoured them would corrupt the table mid-walk or start a phantom lookup.
- The cycle before the hit strobe. A design that loaded base and bounds together, or in the wrong order, would show the wrong value there.

// File: rtl/pgProbePkg.sv
package pgProbePkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HASH,
    S_FETCH,
    S_TAKE,
    S_CMP,
    S_BND,
    S_MAP
  } probeState_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic ldVpn;
    logic ldHash;
    logic ramRead;
    logic takeWord;
    logic stepIdx;
    logic ldBounds;
    logic ldMap;
  } probeStrobes_t;

endpackage

// File: rtl/pgProbeRam.sv
module pgProbeRam #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 41
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end else if (re) begin
      rdata <= mem[addr];
    end
  end

  // R8: the single port never sees a read and a write in the same cycle
  a_r8_port_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(we && re));

endmodule

// File: rtl/pgProbeCtrl.sv
module pgProbeCtrl
  import pgProbePkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          lookupValid,
  input  logic          tagMatch,
  input  logic          slotEmpty,
  input  logic          limitHit,
  output probeStrobes_t strb,
  output logic          idle,
  output logic          busy,
  output logic          doneHit,
  output logic          doneMiss
);
  probeState_t state, stateNxt;
  logic hitSet, missSet;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    hitSet   = 1'b0;
    missSet  = 1'b0;
    unique case (state)
      S_IDLE: if (lookupValid) begin
        strb.ldVpn = 1'b1;
        stateNxt   = S_HASH;
      end
      S_HASH: begin
        strb.ldHash = 1'b1;
        stateNxt    = S_FETCH;
      end
      S_FETCH: begin
        strb.ramRead = 1'b1;
        stateNxt     = S_TAKE;
      end
      S_TAKE: begin
        strb.takeWord = 1'b1;
        stateNxt      = S_CMP;
      end
      S_CMP: begin
        if (slotEmpty) begin
          missSet  = 1'b1;
          stateNxt = S_IDLE;
        end else if (tagMatch) begin
          stateNxt = S_BND;
        end else if (limitHit) begin
          missSet  = 1'b1;
          stateNxt = S_IDLE;
        end else begin
          strb.stepIdx = 1'b1;
          stateNxt     = S_FETCH;
        end
      end
      S_BND: begin
        strb.ldBounds = 1'b1;
        stateNxt      = S_MAP;
      end
      S_MAP: begin
        strb.ldMap = 1'b1;
        hitSet     = 1'b1;
        stateNxt   = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      doneHit  <= 1'b0;
      doneMiss <= 1'b0;
    end else begin
      state    <= stateNxt;
      doneHit  <= hitSet;
      doneMiss <= missSet;
    end
  end

  assign idle = (state == S_IDLE);
  assign busy = !idle;

  // R5: the mapping load always follows the bounds load by one cycle
  a_r5_map_after_bounds: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldMap |-> $past(strb.ldBounds));
  // R5: the hit strobe lasts exactly one cycle
  a_r5_hit_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneHit |=> !doneHit);
  // R6: the two outcomes never coincide
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(doneHit && doneMiss));
  // R10: a done pulse arrives in the first idle cycle after a busy one
  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (doneHit || doneMiss) |-> (!busy && $past(busy)));

endmodule

// File: rtl/pgProbeDatapath.sv
module pgProbeDatapath
  import pgProbePkg::*;
#(
  parameter int VPN_W  = 16,
  parameter int IDX_W  = 8,
  parameter int BASE_W = 16,
  parameter int BND_W  = 8,
  localparam int WORD_W = 1 + VPN_W + BASE_W + BND_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  probeStrobes_t     strb,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [WORD_W-1:0] ramData,
  output logic [IDX_W-1:0]  probeIdx,
  output logic              tagMatch,
  output logic              slotEmpty,
  output logic              limitHit,
  output logic [BASE_W-1:0] baseOut,
  output logic [BND_W-1:0]  boundsOut
);
  localparam int NCH   = (VPN_W + IDX_W - 1) / IDX_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [VPN_W-1:0]  vpnReg;
  logic [IDX_W-1:0]  idxReg;
  logic [IDX_W-1:0]  probeCnt;
  logic [WORD_W-1:0] wordReg;

  logic              wValid;
  logic [VPN_W-1:0]  wTag;
  logic [BASE_W-1:0] wBase;
  logic [BND_W-1:0]  wBnd;

  // fold the page number into an index by XOR of IDX_W-wide chunks
  function automatic logic [IDX_W-1:0] foldHash(input logic [VPN_W-1:0] v);
    logic [NCH*IDX_W-1:0] padded;
    logic [IDX_W-1:0]     h;
    padded            = '0;
    padded[VPN_W-1:0] = v;
    h                 = '0;
    for (int i = 0; i < NCH; i++) h ^= padded[i*IDX_W +: IDX_W];
    return h;
  endfunction

  assign {wValid, wTag, wBase, wBnd} = wordReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnReg    <= '0;
      idxReg    <= '0;
      probeCnt  <= '0;
      wordReg   <= '0;
      baseOut   <= '0;
      boundsOut <= '0;
    end else begin
      if (strb.ldVpn)    vpnReg <= lookupVpn;
      if (strb.ldHash) begin
        idxReg   <= foldHash(vpnReg);
        probeCnt <= '0;
      end
      if (strb.stepIdx) begin
        idxReg   <= idxReg + 1'b1;
        probeCnt <= probeCnt + 1'b1;
      end
      if (strb.takeWord) wordReg   <= ramData;
      if (strb.ldBounds) boundsOut <= wBnd;
      if (strb.ldMap)    baseOut   <= wBase;
    end
  end

  assign probeIdx  = idxReg;
  assign slotEmpty = !wValid;
  assign tagMatch  = wValid && (wTag == vpnReg);
  assign limitHit  = (probeCnt == IDX_W'(DEPTH - 1));

  // R3: a reprobe moves to the next slot, modulo the table size
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepIdx |=> (idxReg == $past(idxReg) + 1'b1));
  // R7: no reprobe is issued once every slot has been tried
  a_r7_probe_cap: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepIdx |-> (probeCnt != IDX_W'(DEPTH - 1)));
  // R6: a miss leaves both payload outputs untouched
  a_r6_hold_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeWord == 1'b0 && strb.ldBounds == 1'b0) |=> $stable(boundsOut));

endmodule

// File: rtl/pgProbeEngine.sv
module pgProbeEngine
  import pgProbePkg::*;
#(
  parameter int VPN_W  = 16,
  parameter int IDX_W  = 8,
  parameter int BASE_W = 16,
  parameter int BND_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  fillIndex,
  input  logic              fillEntryValid,
  input  logic [VPN_W-1:0]  fillTag,
  input  logic [BASE_W-1:0] fillBase,
  input  logic [BND_W-1:0]  fillBounds,
  output logic              busy,
  output logic              doneHit,
  output logic              doneMiss,
  output logic [BASE_W-1:0] baseOut,
  output logic [BND_W-1:0]  boundsOut
);
  localparam int WORD_W = 1 + VPN_W + BASE_W + BND_W;

  probeStrobes_t     strb;
  logic              idle, tagMatch, slotEmpty, limitHit, ramWe;
  logic [IDX_W-1:0]  probeIdx, ramAddr;
  logic [WORD_W-1:0] ramRd;

  assign ramWe   = fillValid && idle;
  assign ramAddr = idle ? fillIndex : probeIdx;

  pgProbeCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid),
    .tagMatch(tagMatch), .slotEmpty(slotEmpty), .limitHit(limitHit),
    .strb(strb), .idle(idle), .busy(busy),
    .doneHit(doneHit), .doneMiss(doneMiss)
  );

  pgProbeDatapath #(
    .VPN_W(VPN_W), .IDX_W(IDX_W), .BASE_W(BASE_W), .BND_W(BND_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .lookupVpn(lookupVpn),
    .ramData(ramRd), .probeIdx(probeIdx), .tagMatch(tagMatch),
    .slotEmpty(slotEmpty), .limitHit(limitHit),
    .baseOut(baseOut), .boundsOut(boundsOut)
  );

  pgProbeRam #(.ADDR_W(IDX_W), .DATA_W(WORD_W)) ram_i (
    .clk(clk), .rstN(rstN), .we(ramWe), .re(strb.ramRead), .addr(ramAddr),
    .wdata({fillEntryValid, fillTag, fillBase, fillBounds}),
    .rdata(ramRd)
  );

endmodule

// File: tb/pgProbeEngine_tb.sv
module pgProbeEngine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [15:0] lookupVpn = '0;
  logic        fillValid = 1'b0;
  logic [7:0]  fillIndex = '0;
  logic        fillEntryValid = 1'b0;
  logic [15:0] fillTag = '0;
  logic [15:0] fillBase = '0;
  logic [7:0]  fillBounds = '0;
  logic        busy, doneHit, doneMiss;
  logic [15:0] baseOut;
  logic [7:0]  boundsOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // reference table kept by the bench
  bit          mV  [256];
  logic [15:0] mT  [256];
  logic [15:0] mB  [256];
  logic [7:0]  mBd [256];

  always #2.5 clk = ~clk;

  pgProbeEngine dut_i (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
    .fillValid(fillValid), .fillIndex(fillIndex), .fillEntryValid(fillEntryValid),
    .fillTag(fillTag), .fillBase(fillBase), .fillBounds(fillBounds),
    .busy(busy), .doneHit(doneHit), .doneMiss(doneMiss),
    .baseOut(baseOut), .boundsOut(boundsOut)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hashOf(input logic [15:0] v);
    return v[15:8] ^ v[7:0];
  endfunction

  // walk the reference table as the requirements describe
  function automatic void predict(input logic [15:0] vpn, output bit hit,
                                  output int probes, output int slot);
    logic [7:0] idx = hashOf(vpn);
    hit = 0; probes = 256; slot = 0;
    for (int p = 1; p <= 256; p++) begin
      if (!mV[idx]) begin hit = 0; probes = p; return; end
      if (mT[idx] == vpn) begin hit = 1; probes = p; slot = idx; return; end
      idx = idx + 8'd1;
    end
  endfunction

  task automatic putEntry(input logic [7:0] idx, input bit v, input logic [15:0] tag,
                          input logic [15:0] base, input logic [7:0] bnd);
    @(negedge clk);
    fillValid = 1; fillIndex = idx; fillEntryValid = v;
    fillTag = tag; fillBase = base; fillBounds = bnd;
    @(posedge clk);
    @(negedge clk);
    fillValid = 0;
    mV[idx] = v; mT[idx] = tag; mB[idx] = base; mBd[idx] = bnd;
  endtask

  task automatic clearTable();
    for (int i = 0; i < 256; i++) putEntry(8'(i), 1'b0, 16'h0, 16'h0, 8'h0);
  endtask

  // run one lookup; optional fill / lookup injected while busy
  task automatic doLookup(input logic [15:0] vpn, input bit injFill, input bit injLook,
                          output int n, output bit h, output bit m,
                          output logic [15:0] b, output logic [7:0] bd,
                          output logic [15:0] pb, output logic [7:0] pbd,
                          output bit busyOk);
    @(negedge clk);
    lookupValid = 1; lookupVpn = vpn;
    @(posedge clk);
    n = 0; h = 0; m = 0; busyOk = 1; b = '0; bd = '0;
    @(negedge clk);
    lookupValid = 0;
    pb = baseOut; pbd = boundsOut;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 2 && injFill) begin
        fillValid = 1; fillIndex = hashOf(vpn); fillEntryValid = 1;
        fillTag = vpn; fillBase = 16'h1111; fillBounds = 8'h11;
      end
      if (n == 2 && injLook) begin
        lookupValid = 1; lookupVpn = vpn ^ 16'h0101;
      end
      if (n == 3) begin fillValid = 0; lookupValid = 0; end
      if (doneHit || doneMiss) begin
        h = doneHit; m = doneMiss; b = baseOut; bd = boundsOut;
        if (busy) busyOk = 0;
        break;
      end
      if (!busy) busyOk = 0;
      pb = baseOut; pbd = boundsOut;
      if (n > 2000) begin
        chk(0, "R10 lookup never finished", n, 0);
        break;
      end
    end
  endtask

  // compare one lookup against the reference table
  task automatic checkLookup(input logic [15:0] vpn, input string tag);
    int n, probes, slot; bit h, m, eh, bOk;
    logic [15:0] b, pb, oldB; logic [7:0] bd, pbd, oldBd;
    oldB = baseOut; oldBd = boundsOut;
    predict(vpn, eh, probes, slot);
    doLookup(vpn, 0, 0, n, h, m, b, bd, pb, pbd, bOk);
    chk(h == eh && m == !eh, {tag, " R4 outcome"}, {h, m}, {eh, !eh});
    if (eh) begin
      chk(n == 3*probes + 3, {tag, " R3 hit latency"}, n, 3*probes + 3);
      chk(b == mB[slot] && bd == mBd[slot], {tag, " R5 payload"}, {b, bd}, {mB[slot], mBd[slot]});
    end else begin
      chk(n == 3*probes + 1, {tag, " R6 miss latency"}, n, 3*probes + 1);
      chk(b == oldB && bd == oldBd, {tag, " R6 outputs held"}, {b, bd}, {oldB, oldBd});
    end
    chk(bOk, {tag, " R10 busy window"}, bOk, 1);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    chk(0, "watchdog expired", cycles, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int n, probes, slot, doneCnt; bit h, m, eh, bOk;
    logic [15:0] b, pb; logic [7:0] bd, pbd;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(!busy && !doneHit && !doneMiss, "R1 control outputs", {busy, doneHit, doneMiss}, 0);
    chk(baseOut == 0 && boundsOut == 0, "R1 payload outputs", {baseOut, boundsOut}, 0);
    rstN = 1;

    clearTable();

    // R6: empty first slot -> miss after one probe
    checkLookup(16'h1234, "empty");

    // R2 / R5: entry at the hashed slot, bounds before base
    putEntry(8'h26, 1, 16'h1234, 16'hBEEF, 8'h5A);
    doLookup(16'h1234, 0, 0, n, h, m, b, bd, pb, pbd, bOk);
    chk(h && n == 6, "R2 single-probe hit after 6 cycles", n, 6);
    chk(b == 16'hBEEF && bd == 8'h5A, "R5 hit payload", {b, bd}, {16'hBEEF, 8'h5A});
    chk(pbd == 8'h5A && pb == 16'h0000, "R5 bounds loads before base", {pb, pbd}, {16'h0, 8'h5A});

    // R4: same hashed slot, tag differs -> reprobe to empty -> miss
    doLookup(16'h3412, 0, 0, n, h, m, b, bd, pb, pbd, bOk);
    chk(m && !h && n == 7, "R4 tag mismatch then empty", n, 7);
    chk(b == 16'hBEEF && bd == 8'h5A, "R6 outputs kept on miss", {b, bd}, {16'hBEEF, 8'h5A});

    // R3: collision resolved at the next slot
    putEntry(8'h27, 1, 16'h3412, 16'hCAFE, 8'h33);
    checkLookup(16'h3412, "R3 collision");

    // R3: wrap from slot 255 to slot 0
    putEntry(8'hFF, 1, 16'hFF00, 16'h0F0F, 8'h01);
    putEntry(8'h00, 1, 16'h00FF, 16'hA5A5, 8'h77);
    doLookup(16'h00FF, 0, 0, n, h, m, b, bd, pb, pbd, bOk);
    chk(h && n == 9 && b == 16'hA5A5 && bd == 8'h77, "R3 wrap hit", {n, b}, {9, 16'hA5A5});

    // R8: a fill issued while busy is dropped
    doLookup(16'h1234, 1, 0, n, h, m, b, bd, pb, pbd, bOk);
    chk(h && b == 16'hBEEF, "R8 lookup unaffected by busy fill", b, 16'hBEEF);
    doLookup(16'h1234, 0, 0, n, h, m, b, bd, pb, pbd, bOk);
    chk(h && b == 16'hBEEF && bd == 8'h5A, "R8 table unchanged after busy fill", {b, bd}, {16'hBEEF, 8'h5A});

    // R9: a lookup request while busy is ignored
    doLookup(16'h1234, 0, 1, n, h, m, b, bd, pb, pbd, bOk);
    chk(h && n == 6, "R9 first lookup intact", n, 6);
    doneCnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy || doneHit || doneMiss) doneCnt++;
    end
    chk(doneCnt == 0, "R9 no phantom lookup", doneCnt, 0);

    // random: half-full table, present and absent pages
    clearTable();
    for (int i = 0; i < 128; i++) begin
      logic [15:0] v; logic [7:0] idx;
      v = 16'($urandom);
      predict(v, eh, probes, slot);
      if (!eh) begin
        idx = hashOf(v);
        while (mV[idx]) idx = idx + 8'd1;
        putEntry(idx, 1, v, 16'($urandom), 8'($urandom));
      end
    end
    for (int i = 0; i < 60; i++) begin
      logic [15:0] v;
      if (i % 2 == 0) begin
        logic [7:0] s;
        s = 8'($urandom);
        while (!mV[s]) s = s + 8'd1;
        v = mT[s];
      end else begin
        v = 16'($urandom);
      end
      checkLookup(v, "random R2");
    end

    // R7: full table without the page -> miss after 256 probes
    for (int i = 0; i < 256; i++) putEntry(8'(i), 1, 16'hFFFF, 16'(i), 8'(i));
    doLookup(16'h0000, 0, 0, n, h, m, b, bd, pb, pbd, bOk);
    chk(m && !h && n == 769, "R7 full-table miss latency", n, 769);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule